// File: doc/BRIEF.md
# Frame playback with preamble and gap insertion

This block replays nibble-wide frames held in a memory. While read enable is high it walks the memory one nibble per cycle. It looks for the two-nibble start delimiter in the stored stream. Once the delimiter is found, it sends a regenerated preamble, then the delimiter, then the frame body on a 4-bit output with a valid flag.

Every nibble passes through a 4-lane delay line whose depth equals the length of the end marker. A stored frame ends with a run of all-ones nibbles as long as that line. When the last nibble of the run arrives, the line holds only marker nibbles. It is then reloaded with zeros, so the marker never reaches the output and becomes the inter-frame gap instead. Memory reads stop while the gap drains. After the gap the block hunts for the next delimiter.

The memory read port is combinational: `mem_data` must carry the nibble stored at `mem_addr` in the same cycle.

Top module: `frame_playback`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mem_addr` is 0, `nib_valid` is 0 and `nib_out` is 0.
- R2: A read is consumed, and `mem_addr` advances by one, on a clock edge exactly when `rd_en` is high and the block is not draining a gap. The address wraps from 2^ADDR_W-1 to 0.
- R3: No frame output starts until the stored stream holds nibble 4'b1010 followed directly by nibble 4'b1011, with the earlier address holding 4'b1010.
- R4: After the delimiter, the valid output stream is 14 nibbles of 4'b0101, then 4'b1010, then 4'b1011, then the frame body in address order. The line has DEPTH-16 unused leading positions, so the first preamble nibble appears while `mem_addr` equals the delimiter's second address plus DEPTH-15.
- R5: `nib_valid` is high only in cycles where `rd_en` is high and a preamble or frame nibble is being driven. When `nib_valid` is low, `nib_out` is 0. Dropping `rd_en` pauses the stream without losing or repeating any nibble.
- R6: A run of DEPTH consecutive 4'b1111 nibbles ends the frame. None of those nibbles is output. The last body nibble is output in the same cycle that the final marker nibble is read.
- R7: A run of fewer than DEPTH 4'b1111 nibbles inside the body is ordinary data and is output unchanged. Any other nibble restarts the run count.
- R8: After the end of a frame, the block drains DEPTH zero-gap cycles. In those cycles `nib_valid` is 0, `nib_out` is 0 and `mem_addr` holds, whatever the state of `rd_en`.
- R9: After the gap, the block hunts again with an empty history, and the next delimiter starts a new frame under R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Permits memory reads and output shifting |
| mem_addr | output | ADDR_W | Read address presented to the frame memory |
| mem_data | input | 4 | Nibble stored at `mem_addr`, same cycle |
| nib_out | output | 4 | Output nibble, zero when not valid |
| nib_valid | output | 1 | High while a preamble or frame nibble is on `nib_out` |

## Verification
The assertions assume the memory returns the nibble at the presented address within the same cycle, and that a stored frame body never ends in 4'b1111 directly before its marker run. If it did, the body and the marker would merge into one longer run. The bench's memory image keeps to both rules: junk between frames never forms the delimiter pair, and body runs of all-ones stop at five and at DEPTH-1. `rd_en` is driven half a clock away from the sampling edge. In the second pass it is pulled low on a fixed cycle pattern, which includes cycles inside the gap, to show that draining does not depend on it.

// File: rtl/fp_pkg.sv
package fp_pkg;

  typedef struct packed {
    logic       vld;
    logic [3:0] nib;
  } fp_slot_t;

  typedef enum logic [1:0] {
    FP_HUNT  = 2'd0,
    FP_PLAY  = 2'd1,
    FP_DRAIN = 2'd2
  } fp_state_e;

  localparam logic [3:0] SYNC_FIRST = 4'b1010;
  localparam logic [3:0] SYNC_SECOND = 4'b1011;
  localparam logic [3:0] PRE_NIB = 4'b0101;
  localparam logic [3:0] MARK_NIB = 4'b1111;
  localparam int PRE_LEN = 14;

  // Content of line position pos (0 = head) after the preamble load.
  // The pattern is anchored at the tail: delimiter last, preamble before it.
  function automatic fp_slot_t pre_slot(input int pos, input int depth);
    int from_tail;
    fp_slot_t s;
    from_tail = depth - 1 - pos;
    if (from_tail == 0)               s = '{vld: 1'b1, nib: SYNC_SECOND};
    else if (from_tail == 1)          s = '{vld: 1'b1, nib: SYNC_FIRST};
    else if (from_tail < PRE_LEN + 2) s = '{vld: 1'b1, nib: PRE_NIB};
    else                              s = '{vld: 1'b0, nib: 4'h0};
    return s;
  endfunction

  function automatic logic is_sync(input logic [3:0] older, input logic [3:0] newer);
    return (older == SYNC_FIRST) && (newer == SYNC_SECOND);
  endfunction

endpackage

// File: rtl/fp_fetch.sv
module fp_fetch
  import fp_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int RUN_LEN = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              hunting,
  input  logic              playing,
  input  logic              rearm,
  input  logic [3:0]        mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              delim_hit,
  output logic              eof_hit
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [3:0]    held;
  logic [CW-1:0] ones_run;
  logic          is_mark;

  assign is_mark   = (mem_data == MARK_NIB);
  assign delim_hit = hunting && adv && is_sync(held, mem_data);
  assign eof_hit   = playing && adv && is_mark && (ones_run == CW'(RUN_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      held     <= 4'h0;
      ones_run <= '0;
    end else begin
      if (adv) mem_addr <= mem_addr + 1'b1;
      if (rearm) held <= 4'h0;
      else if (adv) held <= mem_data;
      if (delim_hit) ones_run <= '0;
      else if (playing && adv) ones_run <= is_mark ? ones_run + 1'b1 : '0;
    end
  end

  // the run counter never passes the marker length inside a frame (R7)
  p_run_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    playing |-> (ones_run < CW'(RUN_LEN)));

endmodule

// File: rtl/fp_line.sv
module fp_line
  import fp_pkg::*;
#(
  parameter int DEPTH = 24
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     shift,
  input  logic     load_pre,
  input  logic     load_gap,
  input  fp_slot_t tail_in,
  output fp_slot_t head
);
  fp_slot_t [DEPTH-1:0] slot;
  fp_slot_t [DEPTH-1:0] nxt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_tail
      assign nxt[i] = load_gap ? fp_slot_t'('0) :
                      load_pre ? pre_slot(i, DEPTH) :
                      shift    ? tail_in : slot[i];
    end else begin : g_body
      assign nxt[i] = load_gap ? fp_slot_t'('0) :
                      load_pre ? pre_slot(i, DEPTH) :
                      shift    ? slot[i+1] : slot[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= nxt;
  end

  assign head = slot[0];

  // a preamble load and a gap load never coincide (R4, R8)
  p_loads_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_pre && load_gap));

endmodule

// File: rtl/fp_ctrl.sv
module fp_ctrl
  import fp_pkg::*;
#(
  parameter int DEPTH = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic delim_hit,
  input  logic eof_hit,
  output logic hunting,
  output logic playing,
  output logic draining,
  output logic rearm
);
  localparam int DCW = $clog2(DEPTH);

  fp_state_e      state;
  logic [DCW-1:0] gap_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FP_HUNT;
      gap_left <= '0;
    end else begin
      case (state)
        FP_HUNT: if (delim_hit) state <= FP_PLAY;
        FP_PLAY: if (eof_hit) begin
          state    <= FP_DRAIN;
          gap_left <= DCW'(DEPTH - 1);
        end
        FP_DRAIN: if (gap_left == '0) state <= FP_HUNT;
                  else gap_left <= gap_left - 1'b1;
        default: state <= FP_HUNT;
      endcase
    end
  end

  assign hunting  = (state == FP_HUNT);
  assign playing  = (state == FP_PLAY);
  assign draining = (state == FP_DRAIN);
  assign rearm    = draining && (gap_left == '0);

  p_eof_to_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eof_hit |=> draining);
  p_play_after_delim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(playing) |-> $past(delim_hit));
  p_rearm_hunt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(draining) |-> hunting);

endmodule

// File: rtl/frame_playback.sv
module frame_playback
  import fp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DEPTH  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [3:0]        mem_data,
  output logic [3:0]        nib_out,
  output logic              nib_valid
);
  localparam int RUN_LEN = DEPTH;

  logic     adv, move;
  logic     delim_hit, eof_hit;
  logic     hunting, playing, draining, rearm;
  fp_slot_t head;

  assign adv  = rd_en && !draining;
  assign move = (playing && adv) || draining;

  fp_fetch #(.ADDR_W(ADDR_W), .RUN_LEN(RUN_LEN)) u_fetch (
    .clk(clk), .rst_n(rst_n), .adv(adv), .hunting(hunting),
    .playing(playing), .rearm(rearm), .mem_data(mem_data),
    .mem_addr(mem_addr), .delim_hit(delim_hit), .eof_hit(eof_hit)
  );

  fp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .delim_hit(delim_hit), .eof_hit(eof_hit),
    .hunting(hunting), .playing(playing), .draining(draining), .rearm(rearm)
  );

  fp_line #(.DEPTH(DEPTH)) u_line (
    .clk(clk), .rst_n(rst_n), .shift(move), .load_pre(delim_hit),
    .load_gap(eof_hit), .tail_in('{vld: 1'b1, nib: mem_data}), .head(head)
  );

  assign nib_valid = move && head.vld;
  assign nib_out   = nib_valid ? head.nib : 4'h0;

  p_valid_needs_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid |-> rd_en);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    draining |=> $stable(mem_addr));
  p_gap_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> (!nib_valid && nib_out == 4'h0));

endmodule

// File: tb/test_frame_playback.sv
module test_frame_playback;
  localparam int AW    = 8;
  localparam int DEPTH = 24;
  localparam int PRE   = 14;
  localparam int NEXP  = 168;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_data, nib_out;
  logic          nib_valid;

  logic [3:0]    mem [256];
  logic [3:0]    exp_nib [NEXP];
  logic          exp_first [NEXP];
  logic          exp_last [NEXP];
  logic [AW-1:0] exp_tag [NEXP];

  int vectors = 0, errors = 0;
  int idx = 0, dl = 0, nfill = 0;
  bit running = 0, have_prev = 0, prev_adv = 0, phase2 = 0;
  logic [AW-1:0] prev_addr = '0;

  always #10 clk = ~clk;

  assign mem_data = mem[mem_addr];

  frame_playback #(.ADDR_W(AW), .DEPTH(DEPTH)) i_frame_playback (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mem_addr(mem_addr),
    .mem_data(mem_data), .nib_out(nib_out), .nib_valid(nib_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [3:0] n, input bit first, input bit last, input int tag);
    exp_nib[nfill] = n;
    exp_first[nfill] = first;
    exp_last[nfill] = last;
    exp_tag[nfill] = AW'(tag);
    nfill++;
  endtask

  // one frame: preamble, delimiter, body from memory, end at marker address
  task automatic push_frame(input int sync_b, input int body_lo, input int body_hi, input int mark_end);
    for (int k = 0; k < PRE; k++) push(4'h5, k == 0, 1'b0, sync_b + 1 + (DEPTH - PRE - 2));
    push(4'hA, 1'b0, 1'b0, 0);
    push(4'hB, 1'b0, 1'b0, 0);
    for (int a = body_lo; a <= body_hi; a++) push(mem[a], 1'b0, a == body_hi, mark_end);
  endtask

  // monitor: sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      logic [AW-1:0] want;
      bit in_drain;
      if (have_prev) begin
        want = prev_adv ? prev_addr + 1'b1 : prev_addr;
        chk(mem_addr == want, "R2 address step/hold (R8 stall)", mem_addr, want);
      end
      in_drain = (dl > 0);
      if (!nib_valid) chk(nib_out == 4'h0, "R5 output zero when not valid", nib_out, 0);
      if (in_drain) begin
        chk(!nib_valid, "R8 gap cycle not valid", nib_valid, 0);
        dl--;
      end else if (!rd_en) begin
        chk(!nib_valid, "R5 paused while rd_en low", nib_valid, 0);
      end
      prev_adv  = rd_en && !in_drain;
      prev_addr = mem_addr;
      have_prev = 1;
      if (nib_valid) begin
        if (idx < NEXP) begin
          chk(nib_out == exp_nib[idx], "R4/R7 output nibble", nib_out, exp_nib[idx]);
          if (exp_first[idx])
            chk(mem_addr == exp_tag[idx], "R3/R9 first preamble timing", mem_addr, exp_tag[idx]);
          if (exp_last[idx]) begin
            chk(mem_addr == exp_tag[idx], "R6 end at last marker nibble", mem_addr, exp_tag[idx]);
            dl = DEPTH;
          end
        end
        idx++;
      end
    end
  end

  initial begin
    int cyc;
    int post;
    for (int a = 0; a < 256; a++) mem[a] = 4'h0;
    mem[0] = 4'h5; mem[1] = 4'hA; mem[2] = 4'hA; mem[3] = 4'h3;
    mem[4] = 4'hA; mem[5] = 4'hB;
    for (int k = 0; k < 36; k++)
      mem[6 + k] = (k < 4) ? 4'(k + 1) : (k < 9) ? 4'hF : (k == 9) ? 4'h7 :
                   (k < 33) ? 4'hF : (k == 33) ? 4'h2 : (k == 34) ? 4'h8 : 4'h9;
    for (int a = 42; a <= 65; a++) mem[a] = 4'hF;
    mem[66] = 4'hB; mem[67] = 4'hA; mem[68] = 4'hC; mem[69] = 4'h0;
    mem[70] = 4'hA; mem[71] = 4'hB;
    for (int k = 0; k < 16; k++) mem[72 + k] = 4'((k * 5) & 15);
    for (int a = 88; a <= 111; a++) mem[a] = 4'hF;
    for (int r = 0; r < 2; r++) begin
      push_frame(5, 6, 41, 65);
      push_frame(71, 72, 87, 111);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_addr == '0, "R1 reset address", mem_addr, 0);
    chk(!nib_valid && nib_out == 4'h0, "R1 reset output", {nib_valid, nib_out}, 0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    rd_en = 1'b1;
    running = 1;
    @(negedge clk);
    chk(mem_addr == '0 && !nib_valid, "R1 first cycle after reset", mem_addr, 0);

    cyc = 0;
    post = 0;
    while (post < 60 && cyc < 20000) begin
      @(posedge clk);
      #2;
      cyc++;
      if (idx >= 84) phase2 = 1;
      rd_en = phase2 ? (cyc % 5 != 3) : 1'b1;
      if (idx >= NEXP) post++;
    end
    if (cyc >= 20000) begin
      vectors++;
      errors++;
      $display("FAIL watchdog R6 stream incomplete actual=%0d expected=%0d", idx, NEXP);
    end
    chk(idx == NEXP, "R6 total valid nibbles", idx, NEXP);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule